// File: doc/BRIEF.md
# Slow-Card Retry and Cycle-Matching Controller

This block is the slave end of a fast host bus that reaches a slow removable-card target. A host request that finds the controller idle starts a card transfer straight away. If the card finishes promptly, the host gets a normal acknowledge. If the card raises its wait line, or the transfer runs past a time limit counted in microsecond ticks, the controller answers the host with a retry. This frees the host bus while the card transfer keeps running in the background. The controller remembers the address, transfer size and direction of that split cycle. Only a later host cycle with all three equal may collect the result. Every other host cycle is retried until the buffered result has been collected.

The controller is one state machine with four named states. IDLE means nothing is outstanding. ACTIVE means the card is busy and the host is still waiting for it. BACKGROUND means the host was released with a retry while the card is still busy. READY means the card has finished after a retry and its result sits in a buffer for the matching host cycle.

The transitions are named as follows. START goes from IDLE to ACTIVE on a host request. QUICK_DONE goes from ACTIVE to IDLE when the card finishes, with an acknowledge. SPLIT goes from ACTIVE to BACKGROUND on wait or timeout, with a retry. LATE_DONE goes from BACKGROUND to READY when the card finishes. COLLECT goes from READY to IDLE on a matching host cycle, with an acknowledge. The self-loops REJECT_BUSY (BACKGROUND) and REJECT_MISMATCH (READY) answer host cycles with a retry.

Top module: `slow_retry_ctrl`

## Requirements
- R1: A host request sampled in IDLE raises card_req at the same clock edge. card_addr, card_size, card_write and card_wdata then carry that request's address, size, direction and write data.
- R2: When card_done is sampled in ACTIVE, host_ack is high for the cycle after that edge, with host_retry low. For a read, host_rdata equals card_rdata; for a write, host_rdata is zero.
- R3: When card_wait is sampled high in ACTIVE and card_done is low, host_retry is high for the cycle after that edge, and card_req stays high.
- R4: us_tick pulses are counted while in ACTIVE. The LIMIT_US-th tick (default 10) produces a retry in the following cycle; earlier ticks produce no response.
- R5: If card_done is sampled in the same cycle as card_wait, the host gets an acknowledge and no retry.
- R6: While a split transfer is still running on the card, every host request is answered with a retry the next cycle, whether it matches or not. It starts no new card transfer, and card_addr is unchanged.
- R7: Once the split transfer has finished, a host request whose address, size and direction all equal the latched ones gets host_ack the next cycle. A read returns the buffered card data. The pending state clears, so the next request starts a new card transfer.
- R8: Once the split transfer has finished, a host request that differs in address, in size or in direction is answered with a retry, and the buffered result stays available. Size codes: 0 byte, 1 halfword, 2 word.
- R9: For a split write, card_wdata keeps the data of the first attempt until the card finishes. The matching reissue is acknowledged only after card_done.
- R10: Each host request receives exactly one response. host_ack and host_retry are never high together, and an acknowledge lasts one cycle.
- R11: A synchronous active-high reset drops card_req and both responses, clears any pending split cycle and clears the timeout counter.
- R12: card_req falls at the same clock edge that samples card_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | One-cycle host request strobe |
| host_addr | input | AW | Request address |
| host_size | input | 2 | Transfer size code (0 byte, 1 halfword, 2 word) |
| host_write | input | 1 | 1 = write, 0 = read |
| host_wdata | input | DW | Write data |
| host_ack | output | 1 | One-cycle normal acknowledge |
| host_retry | output | 1 | One-cycle retry acknowledge |
| host_rdata | output | DW | Read data, valid with host_ack |
| card_req | output | 1 | Card transfer in progress, held until card_done |
| card_addr | output | AW | Latched address for the card |
| card_size | output | 2 | Latched size for the card |
| card_write | output | 1 | Latched direction for the card |
| card_wdata | output | DW | Latched write data for the card |
| card_wait | input | 1 | Card stall indication |
| card_done | input | 1 | One-cycle card completion strobe |
| card_rdata | input | DW | Card read data, valid with card_done |
| us_tick | input | 1 | One-cycle pulse every microsecond |

## Verification
Every response is registered. card_req follows the edge that samples host_req, and host_ack or host_retry appear in the cycle after the edge that samples their cause: card_done, card_wait, the last counted tick, or a host request in BACKGROUND or READY. The bench drives inputs on the falling edge and checks the named output at the next falling edge, so each check lands exactly one rising edge after its stimulus. For the single-cycle rules it also checks the following falling edge. The timeout is checked after every tick, so a response that comes one tick early or one tick late is caught.

// File: rtl/retry_pkg.sv
package retry_pkg;
    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_ACTIVE     = 2'd1,
        ST_BACKGROUND = 2'd2,
        ST_READY      = 2'd3
    } rc_state_t;

    localparam int SIZE_W = 2;
    localparam logic [SIZE_W-1:0] SZ_BYTE = 2'd0;
    localparam logic [SIZE_W-1:0] SZ_HALF = 2'd1;
    localparam logic [SIZE_W-1:0] SZ_WORD = 2'd2;
endpackage

// File: rtl/retry_timer.sv
module retry_timer #(
    parameter int LIMIT = 10,
    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic expired
);
    logic [CW-1:0] cnt;

    assign expired = run && tick && (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= expired ? '0 : cnt + 1'b1;
        end
    end

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt < CW'(LIMIT));

    // R11
    cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0));
endmodule

// File: rtl/cycle_match.sv
module cycle_match #(
    parameter int AW = 32,
    parameter int SW = 2
) (
    input  logic [AW-1:0] req_addr,
    input  logic [SW-1:0] req_size,
    input  logic          req_write,
    input  logic [AW-1:0] held_addr,
    input  logic [SW-1:0] held_size,
    input  logic          held_write,
    output logic          hit
);
    logic addr_eq, size_eq, dir_eq;

    always_comb begin
        addr_eq = (req_addr == held_addr);
        size_eq = (req_size == held_size);
        dir_eq  = (req_write == held_write);
        hit     = addr_eq && size_eq && dir_eq;
    end
endmodule

// File: rtl/slow_retry_ctrl.sv
module slow_retry_ctrl
    import retry_pkg::*;
#(
    parameter int AW       = 32,
    parameter int DW       = 32,
    parameter int LIMIT_US = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic [AW-1:0]     host_addr,
    input  logic [SIZE_W-1:0] host_size,
    input  logic              host_write,
    input  logic [DW-1:0]     host_wdata,
    output logic              host_ack,
    output logic              host_retry,
    output logic [DW-1:0]     host_rdata,
    output logic              card_req,
    output logic [AW-1:0]     card_addr,
    output logic [SIZE_W-1:0] card_size,
    output logic              card_write,
    output logic [DW-1:0]     card_wdata,
    input  logic              card_wait,
    input  logic              card_done,
    input  logic [DW-1:0]     card_rdata,
    input  logic              us_tick
);
    rc_state_t state, nxt_state;

    logic [AW-1:0]     lat_addr;
    logic [SIZE_W-1:0] lat_size;
    logic              lat_write;
    logic [DW-1:0]     lat_wdata;
    logic [DW-1:0]     rdata_buf;

    logic give_ack, give_retry, start_xfer, end_xfer;
    logic expired, hit;

    retry_timer #(.LIMIT(LIMIT_US)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (state == ST_ACTIVE),
        .tick    (us_tick),
        .expired (expired)
    );

    cycle_match #(.AW(AW), .SW(SIZE_W)) u_match (
        .req_addr   (host_addr),
        .req_size   (host_size),
        .req_write  (host_write),
        .held_addr  (lat_addr),
        .held_size  (lat_size),
        .held_write (lat_write),
        .hit        (hit)
    );

    // next state and response decision
    always_comb begin
        nxt_state  = state;
        give_ack   = 1'b0;
        give_retry = 1'b0;
        start_xfer = 1'b0;
        end_xfer   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (host_req) begin
                    start_xfer = 1'b1;
                    nxt_state  = ST_ACTIVE;
                end
            end
            ST_ACTIVE: begin
                if (card_done) begin
                    give_ack  = 1'b1;
                    end_xfer  = 1'b1;
                    nxt_state = ST_IDLE;
                end else if (card_wait || expired) begin
                    give_retry = 1'b1;
                    nxt_state  = ST_BACKGROUND;
                end
            end
            ST_BACKGROUND: begin
                if (host_req) begin
                    give_retry = 1'b1;
                end
                if (card_done) begin
                    end_xfer  = 1'b1;
                    nxt_state = ST_READY;
                end
            end
            ST_READY: begin
                if (host_req) begin
                    if (hit) begin
                        give_ack  = 1'b1;
                        nxt_state = ST_IDLE;
                    end else begin
                        give_retry = 1'b1;
                    end
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt_state;
        end
    end

    // registered outputs and latched cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            lat_addr   <= '0;
            lat_size   <= '0;
            lat_write  <= 1'b0;
            lat_wdata  <= '0;
            rdata_buf  <= '0;
            card_req   <= 1'b0;
            host_ack   <= 1'b0;
            host_retry <= 1'b0;
            host_rdata <= '0;
        end else begin
            host_ack   <= give_ack;
            host_retry <= give_retry;
            if (give_ack && !lat_write) begin
                host_rdata <= (state == ST_ACTIVE) ? card_rdata : rdata_buf;
            end else begin
                host_rdata <= '0;
            end
            if (start_xfer) begin
                lat_addr  <= host_addr;
                lat_size  <= host_size;
                lat_write <= host_write;
                lat_wdata <= host_wdata;
                card_req  <= 1'b1;
            end
            if (end_xfer) begin
                card_req  <= 1'b0;
                rdata_buf <= card_rdata;
            end
        end
    end

    assign card_addr  = lat_addr;
    assign card_size  = lat_size;
    assign card_write = lat_write;
    assign card_wdata = lat_wdata;

    // R10
    one_resp_chk: assert property (@(posedge clk) disable iff (rst)
        !(host_ack && host_retry));

    // R10
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        host_ack |=> !host_ack);

    // R12
    card_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (card_req && card_done) |=> !card_req);

    // R6
    card_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (card_req && !card_done) |=> (card_req && $stable(card_addr) && $stable(card_wdata)));

    // R1
    card_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(card_req) |-> ($past(state) == ST_IDLE && $past(host_req)));

    // R7
    ack_cause_chk: assert property (@(posedge clk) disable iff (rst)
        host_ack |-> ($past(card_done) || $past(state) == ST_READY));
endmodule

// File: tb/slow_retry_ctrl_test.sv
module slow_retry_ctrl_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        host_req;
    logic [31:0] host_addr;
    logic [1:0]  host_size;
    logic        host_write;
    logic [31:0] host_wdata;
    logic        host_ack;
    logic        host_retry;
    logic [31:0] host_rdata;
    logic        card_req;
    logic [31:0] card_addr;
    logic [1:0]  card_size;
    logic        card_write;
    logic [31:0] card_wdata;
    logic        card_wait;
    logic        card_done;
    logic [31:0] card_rdata;
    logic        us_tick;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    slow_retry_ctrl uut (
        .clk(clk), .rst(rst), .host_req(host_req), .host_addr(host_addr),
        .host_size(host_size), .host_write(host_write), .host_wdata(host_wdata),
        .host_ack(host_ack), .host_retry(host_retry), .host_rdata(host_rdata),
        .card_req(card_req), .card_addr(card_addr), .card_size(card_size),
        .card_write(card_write), .card_wdata(card_wdata), .card_wait(card_wait),
        .card_done(card_done), .card_rdata(card_rdata), .us_tick(us_tick)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic [1:0]  size;
        logic        wr;
        logic [31:0] data;
        logic [3:0]  delay;
        logic        stall;
    } vec_t;

    localparam vec_t VECS [0:5] = '{
        '{32'h0000_1000, 2'd2, 1'b0, 32'hCAFE_0001, 4'd2, 1'b0},
        '{32'h0000_2004, 2'd1, 1'b1, 32'h1234_5678, 4'd0, 1'b0},
        '{32'h0000_3008, 2'd0, 1'b0, 32'h0000_00A5, 4'd3, 1'b1},
        '{32'h0000_400C, 2'd2, 1'b1, 32'hDEAD_BEEF, 4'd1, 1'b1},
        '{32'h0000_5010, 2'd2, 1'b0, 32'h5555_AAAA, 4'd5, 1'b0},
        '{32'h0000_6014, 2'd1, 1'b0, 32'h0F0F_F0F0, 4'd0, 1'b1}
    };

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] a, input logic [1:0] s, input logic w,
                         input logic [31:0] d);
        host_addr  = a;
        host_size  = s;
        host_write = w;
        host_wdata = d;
        host_req   = 1'b1;
        @(negedge clk);
        host_req   = 1'b0;
    endtask

    task automatic finish_card(input logic [31:0] d);
        card_done  = 1'b1;
        card_rdata = d;
        @(negedge clk);
        card_done  = 1'b0;
    endtask

    task automatic pulse_tick();
        us_tick = 1'b1;
        @(negedge clk);
        us_tick = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #1_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; host_req = 1'b0; host_addr = '0; host_size = '0; host_write = 1'b0;
        host_wdata = '0; card_wait = 1'b0; card_done = 1'b0; card_rdata = '0; us_tick = 1'b0;
        @(negedge clk);
        do_reset();

        // R11 reset state
        chk("R11 card_req", {63'd0, card_req}, 64'd0);
        chk("R11 ack/retry", {62'd0, host_ack, host_retry}, 64'd0);

        // table of vectors: R1 R2 R3 R7 R9 R10 R12
        foreach (VECS[i]) begin
            vec_t v = VECS[i];
            logic [31:0] exp_rd = v.wr ? 32'd0 : v.data;
            issue(v.addr, v.size, v.wr, v.data);
            chk("R1 card_req", {63'd0, card_req}, 64'd1);
            chk("R1 card attrs", {29'd0, card_addr, card_size, card_write},
                {29'd0, v.addr, v.size, v.wr});
            chk("R1 card_wdata", {32'd0, card_wdata}, {32'd0, v.data});
            if (!v.stall) begin
                repeat (v.delay) @(negedge clk);
                finish_card(v.data);
                chk("R2 ack", {62'd0, host_ack, host_retry}, 64'd2);
                chk("R2 rdata", {32'd0, host_rdata}, {32'd0, exp_rd});
                chk("R12 card_req low", {63'd0, card_req}, 64'd0);
                @(negedge clk);
                chk("R10 ack single", {63'd0, host_ack}, 64'd0);
            end else begin
                card_wait = 1'b1;
                @(negedge clk);
                card_wait = 1'b0;
                chk("R3 retry", {62'd0, host_ack, host_retry}, 64'd1);
                chk("R3 card_req held", {63'd0, card_req}, 64'd1);
                @(negedge clk);
                chk("R10 retry single", {63'd0, host_retry}, 64'd0);
                repeat (v.delay) @(negedge clk);
                chk("R9 wdata held", {32'd0, card_wdata}, {32'd0, v.data});
                finish_card(v.data);
                chk("R12 card_req low", {63'd0, card_req}, 64'd0);
                chk("R9 no ack before reissue", {62'd0, host_ack, host_retry}, 64'd0);
                issue(v.addr, v.size, v.wr, ~v.data);
                chk("R7 collect ack", {62'd0, host_ack, host_retry}, 64'd2);
                chk("R7 collect rdata", {32'd0, host_rdata}, {32'd0, exp_rd});
                chk("R7 no new transfer", {63'd0, card_req}, 64'd0);
            end
        end

        // R4 timeout after LIMIT_US ticks
        issue(32'h0000_7000, 2'd2, 1'b0, 32'd0);
        for (int k = 1; k <= 10; k++) begin
            pulse_tick();
            chk("R4 tick response", {63'd0, host_retry}, (k == 10) ? 64'd1 : 64'd0);
            @(negedge clk);
        end
        finish_card(32'h7777_0000);
        issue(32'h0000_7000, 2'd2, 1'b0, 32'd0);
        chk("R4 collect after timeout", {32'd0, host_rdata}, {32'd0, 32'h7777_0000});

        // R5 done wins over wait
        issue(32'h0000_8000, 2'd2, 1'b0, 32'd0);
        card_wait = 1'b1;
        finish_card(32'h8888_8888);
        card_wait = 1'b0;
        chk("R5 ack over wait", {62'd0, host_ack, host_retry}, 64'd2);
        chk("R5 rdata", {32'd0, host_rdata}, {32'd0, 32'h8888_8888});
        @(negedge clk);

        // R6 / R8 outstanding split read
        issue(32'h0000_9000, 2'd1, 1'b0, 32'd0);
        card_wait = 1'b1;
        @(negedge clk);
        card_wait = 1'b0;
        @(negedge clk);
        issue(32'h0000_A000, 2'd2, 1'b1, 32'h1111_1111);
        chk("R6 mismatch busy retry", {62'd0, host_ack, host_retry}, 64'd1);
        chk("R6 card addr kept", {32'd0, card_addr}, {32'd0, 32'h0000_9000});
        chk("R6 card still busy", {63'd0, card_req}, 64'd1);
        @(negedge clk);
        issue(32'h0000_9000, 2'd1, 1'b0, 32'd0);
        chk("R6 match busy retry", {62'd0, host_ack, host_retry}, 64'd1);
        @(negedge clk);
        finish_card(32'h9999_1234);
        issue(32'h0000_9004, 2'd1, 1'b0, 32'd0);
        chk("R8 addr differs", {62'd0, host_ack, host_retry}, 64'd1);
        @(negedge clk);
        issue(32'h0000_9000, 2'd2, 1'b0, 32'd0);
        chk("R8 size differs", {62'd0, host_ack, host_retry}, 64'd1);
        @(negedge clk);
        issue(32'h0000_9000, 2'd1, 1'b1, 32'd0);
        chk("R8 dir differs", {62'd0, host_ack, host_retry}, 64'd1);
        chk("R8 no new transfer", {63'd0, card_req}, 64'd0);
        @(negedge clk);
        issue(32'h0000_9000, 2'd1, 1'b0, 32'd0);
        chk("R7 match ack", {62'd0, host_ack, host_retry}, 64'd2);
        chk("R8 result kept", {32'd0, host_rdata}, {32'd0, 32'h9999_1234});
        @(negedge clk);
        issue(32'h0000_B000, 2'd0, 1'b0, 32'd0);
        chk("R7 pending cleared", {31'd0, card_req, card_addr}, {31'd0, 1'b1, 32'h0000_B000});
        finish_card(32'h0);
        @(negedge clk);

        // R11 reset clears pending split cycle and timer
        issue(32'h0000_C000, 2'd2, 1'b0, 32'd0);
        card_wait = 1'b1;
        @(negedge clk);
        card_wait = 1'b0;
        do_reset();
        chk("R11 card_req cleared", {63'd0, card_req}, 64'd0);
        issue(32'h0000_D000, 2'd2, 1'b0, 32'd0);
        chk("R11 new transfer", {31'd0, card_req, card_addr}, {31'd0, 1'b1, 32'h0000_D000});
        for (int k = 1; k <= 5; k++) begin
            pulse_tick();
        end
        do_reset();
        issue(32'h0000_E000, 2'd2, 1'b0, 32'd0);
        for (int k = 1; k <= 10; k++) begin
            pulse_tick();
            chk("R11 timer restarts", {63'd0, host_retry}, (k == 10) ? 64'd1 : 64'd0);
        end
        finish_card(32'h0);
        @(negedge clk);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule